// File: doc/BRIEF.md
# Field-Synchronous Shadow Register Bank

This block holds the picture-adjustment settings of a video output path: two caption data bytes, a brightness offset, two colour-difference scale factors, a contrast gain, a hue offset and a one-bit gamma-curve choice. A host writes them over a plain parallel bus (address, data, write strobe). Every register has two copies. The shadow copy takes each host write. The active copy drives the datapath.

A control bit picks the update policy. With buffering off, a write goes to both copies, so the active value changes one clock later. With buffering on, writes reach only the shadow copy. The whole shadow set moves into the active copy in a single clock once per field, when the vertical sync input falls. That edge is found after a two-flop synchronizer, so settings change only between fields and never inside the visible picture.

If a write and the field transfer land in the same clock, the write reaches only the shadow copy and waits for the next field. Clearing the buffering bit while it is set flushes every pending shadow value to the active copy at once. Host reads always return the shadow copy.

Top module: `vid_shadow_bank`

## Requirements
- R1: After synchronous reset the active outputs and the read-back values are: caption bytes 0x00, brightness 0x00, both scale factors 0x80, contrast 0x80, hue 0x00, gamma select 0. Buffering is off.
- R2: Register map: 0 caption low byte, 1 caption high byte, 2 brightness, 3 U scale, 4 V scale, 5 contrast, 6 hue, 7 control. In the control register, bit 0 is gamma select and bit 1 is buffering enable. The other control bits are not stored and read back as 0.
- R3: With buffering off, a write changes the matching active output at the clock edge that takes the write.
- R4: With buffering on, host writes leave every active output unchanged until a field transfer.
- R5: With buffering on, a falling edge of vsync_in loads every active output from the shadow copy, all in the same clock. The load lands on the third rising clock edge after the low level is first sampled. A rising edge of vsync_in causes no transfer.
- R6: A write in the same clock as a field transfer lands in the shadow copy only. The active output keeps the value the shadow held before that write until the next falling edge.
- R7: Writing the buffering bit to 0 while it is 1 copies all shadow values to the active outputs on the following clock.
- R8: Reads return the shadow value of rd_addr_i one clock after the address is presented.
- R9: The buffering-enable bit takes effect as soon as it is written. It is reported on dbuf_on_o without waiting for a field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 3 | Host write address |
| wr_data_i | input | DATA_W | Host write data |
| rd_addr_i | input | 3 | Host read address |
| rd_data_o | output | DATA_W | Shadow value of the read address, one cycle late |
| vsync_i | input | 1 | Asynchronous vertical sync |
| cc_lo_o | output | DATA_W | Active caption low byte |
| cc_hi_o | output | DATA_W | Active caption high byte |
| bright_o | output | DATA_W | Active brightness |
| uscale_o | output | DATA_W | Active U scale |
| vscale_o | output | DATA_W | Active V scale |
| contrast_o | output | DATA_W | Active contrast |
| hue_o | output | DATA_W | Active hue |
| gamma_sel_o | output | 1 | Active gamma-curve select |
| dbuf_on_o | output | 1 | Buffering enable currently in force |

## Verification
Every address is swept with several data patterns in immediate mode. This separates a wrong address decode or a dropped bit from a missing update. The same sweep then runs with buffering on. Here the active outputs must stay frozen, and they must all change together on a vsync fall but not on a rise. The sync-to-load latency is probed clock by clock. One write is placed in the exact transfer clock. Buffering is also switched off with writes still pending, which tells the collision rule and the flush rule apart from a plain load.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  localparam int NREG      = 8;
  localparam int ADDR_W    = 3;
  localparam int CTRL_IDX  = 7;
  localparam int GAMMA_BIT = 0;
  localparam int DBUF_BIT  = 1;
endpackage

// File: rtl/vsb_vsync_edge.sv
module vsb_vsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync_i,
  output logic fall_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-1:0], vsync_i};
  end

  assign fall_o = pipe[STAGES] & ~pipe[STAGES-1];

  assert_one_cycle_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/vsb_shadow.sv
module vsb_shadow
  import vsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [NREG*DATA_W-1:0] DEFLT = '0,
  parameter logic [NREG*DATA_W-1:0] MASK  = '1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic [NREG*DATA_W-1:0]   shd_flat_o
);
  logic [DATA_W-1:0] shd [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        shd[i] <= DEFLT[i*DATA_W +: DATA_W];
      else if (wr_en_i && wr_addr_i == ADDR_W'(i))
        shd[i] <= wr_data_i & MASK[i*DATA_W +: DATA_W];
    end
    assign shd_flat_o[i*DATA_W +: DATA_W] = shd[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= shd[rd_addr_i];
  end

  assert_read_shadow_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en_i && wr_addr_i == rd_addr_i) |=> rd_data_o == shd[$past(rd_addr_i)]);
endmodule

// File: rtl/vsb_active.sv
module vsb_active
  import vsb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [NREG*DATA_W-1:0] DEFLT = '0,
  parameter logic [NREG*DATA_W-1:0] MASK  = '1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic                   dbuf_en_i,
  input  logic                   load_all_i,
  input  logic [NREG*DATA_W-1:0] shd_flat_i,
  output logic [NREG*DATA_W-1:0] act_flat_o
);
  logic [DATA_W-1:0] act [NREG];
  logic [DATA_W-1:0] msk [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign msk[i] = MASK[i*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (rst)
        act[i] <= DEFLT[i*DATA_W +: DATA_W];
      else if (!dbuf_en_i && wr_en_i && wr_addr_i == ADDR_W'(i))
        act[i] <= wr_data_i & msk[i];
      else if (load_all_i)
        act[i] <= shd_flat_i[i*DATA_W +: DATA_W] & msk[i];
    end
    assign act_flat_o[i*DATA_W +: DATA_W] = act[i];
  end

  assert_buffered_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (dbuf_en_i && !load_all_i) |=> $stable(act_flat_o));

  assert_direct_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!dbuf_en_i && wr_en_i) |=>
      act[$past(wr_addr_i)] == ($past(wr_data_i) & msk[$past(wr_addr_i)]));
endmodule

// File: rtl/vid_shadow_bank.sv
module vid_shadow_bank
  import vsb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [2:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              vsync_i,
  output logic [DATA_W-1:0] cc_lo_o,
  output logic [DATA_W-1:0] cc_hi_o,
  output logic [DATA_W-1:0] bright_o,
  output logic [DATA_W-1:0] uscale_o,
  output logic [DATA_W-1:0] vscale_o,
  output logic [DATA_W-1:0] contrast_o,
  output logic [DATA_W-1:0] hue_o,
  output logic              gamma_sel_o,
  output logic              dbuf_on_o
);
  localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W-1);
  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [DATA_W-1:0] CTRL_SHD_M = DATA_W'(3);
  localparam logic [DATA_W-1:0] CTRL_ACT_M = DATA_W'(1);
  localparam logic [NREG*DATA_W-1:0] DEFLT =
    {ZERO, ZERO, MID, MID, MID, ZERO, ZERO, ZERO};
  localparam logic [NREG*DATA_W-1:0] SHD_MASK =
    {CTRL_SHD_M, ONES, ONES, ONES, ONES, ONES, ONES, ONES};
  localparam logic [NREG*DATA_W-1:0] ACT_MASK =
    {CTRL_ACT_M, ONES, ONES, ONES, ONES, ONES, ONES, ONES};

  logic [NREG*DATA_W-1:0] shd_flat, act_flat;
  logic fall, dbuf_en, dbuf_q, load_all;

  vsb_vsync_edge #(.STAGES(SYNC_STGS)) u_edge (
    .clk(clk), .rst(rst), .vsync_i(vsync_i), .fall_o(fall));

  vsb_shadow #(.DATA_W(DATA_W), .DEFLT(DEFLT), .MASK(SHD_MASK)) u_shd (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .shd_flat_o(shd_flat));

  assign dbuf_en = shd_flat[CTRL_IDX*DATA_W + DBUF_BIT];

  always_ff @(posedge clk) begin
    if (rst) dbuf_q <= 1'b0;
    else     dbuf_q <= dbuf_en;
  end

  assign load_all = (dbuf_en & fall) | (dbuf_q & ~dbuf_en);

  vsb_active #(.DATA_W(DATA_W), .DEFLT(DEFLT), .MASK(ACT_MASK)) u_act (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .dbuf_en_i(dbuf_en), .load_all_i(load_all),
    .shd_flat_i(shd_flat), .act_flat_o(act_flat));

  assign cc_lo_o     = act_flat[0*DATA_W +: DATA_W];
  assign cc_hi_o     = act_flat[1*DATA_W +: DATA_W];
  assign bright_o    = act_flat[2*DATA_W +: DATA_W];
  assign uscale_o    = act_flat[3*DATA_W +: DATA_W];
  assign vscale_o    = act_flat[4*DATA_W +: DATA_W];
  assign contrast_o  = act_flat[5*DATA_W +: DATA_W];
  assign hue_o       = act_flat[6*DATA_W +: DATA_W];
  assign gamma_sel_o = act_flat[CTRL_IDX*DATA_W + GAMMA_BIT];
  assign dbuf_on_o   = dbuf_en;

  assert_field_load_R5: assert property (@(posedge clk) disable iff (rst)
    (dbuf_en && fall) |=> act_flat == ($past(shd_flat) & ACT_MASK));

  assert_flush_on_disable_R7: assert property (@(posedge clk) disable iff (rst)
    (dbuf_q && !dbuf_en && !wr_en_i) |=> act_flat == ($past(shd_flat) & ACT_MASK));
endmodule

// File: tb/tb_vid_shadow_bank.sv
module tb_vid_shadow_bank;
  logic clk = 0, rst = 1, wr_en = 0, vsync = 1;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [7:0] cc_lo, cc_hi, bright, uscale, vscale, contrast, hue;
  logic gamma_sel, dbuf_on;
  int total = 0, bad = 0;
  logic [7:0] sh [8];
  logic [7:0] ac [8];
  bit done = 0;

  always #2 clk = ~clk;

  vid_shadow_bank dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .vsync_i(vsync), .cc_lo_o(cc_lo), .cc_hi_o(cc_hi), .bright_o(bright),
    .uscale_o(uscale), .vscale_o(vscale), .contrast_o(contrast), .hue_o(hue),
    .gamma_sel_o(gamma_sel), .dbuf_on_o(dbuf_on));

  function automatic logic [7:0] act_port(int a);
    case (a)
      0: return cc_lo;    1: return cc_hi;   2: return bright;
      3: return uscale;   4: return vscale;  5: return contrast;
      6: return hue;      default: return {7'd0, gamma_sel};
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // R2 control register: bits 1:0 stored in the shadow, bit 0 only in the active copy
  task automatic wr(int a, logic [7:0] d);
    logic [7:0] m;
    m = (a == 7) ? 8'h03 : 8'hFF;
    wr_en = 1; wr_addr = 3'(a); wr_data = d;
    if (!sh[7][1]) ac[a] = d & ((a == 7) ? 8'h01 : 8'hFF);
    sh[a] = d & m;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic load_model();
    for (int i = 0; i < 8; i++) ac[i] = sh[i] & ((i == 7) ? 8'h01 : 8'hFF);
  endtask

  task automatic chk_act(string req);
    for (int i = 0; i < 8; i++) check(req, act_port(i), ac[i]);
    check(req, {7'd0, dbuf_on}, {7'd0, sh[7][1]});
  endtask

  task automatic chk_read(string req);
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      @(negedge clk);
      check(req, rd_data, sh[i]);
    end
  endtask

  task automatic field();
    vsync = 0; cyc(5);
    vsync = 1; cyc(5);
    if (sh[7][1]) load_model();
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [5];
    logic [7:0] old5;
    pats = '{8'h00, 8'hFF, 8'h55, 8'hA5, 8'h3C};
    for (int i = 0; i < 8; i++) begin
      sh[i] = (i >= 3 && i <= 5) ? 8'h80 : 8'h00;
      ac[i] = sh[i];
    end
    cyc(3); rst = 0; cyc(1);
    chk_act("R1 reset"); chk_read("R1 reset readback");

    // R3, R2: immediate mode sweep over all data registers
    for (int a = 0; a < 7; a++)
      for (int p = 0; p < 5; p++) begin
        wr(a, pats[p] ^ 8'(a * 17));
        check("R3 immediate", act_port(a), ac[a]);
      end
    wr(7, 8'hFD);          // R2 unused control bits dropped, gamma=1, buffering stays off
    chk_act("R2 control immediate"); chk_read("R2 R8 readback");
    wr(7, 8'h00);

    // R9: buffering enable visible at once
    wr(7, 8'h02);
    check("R9 dbuf immediate", {7'd0, dbuf_on}, 8'h01);

    // R4: buffered writes freeze active outputs
    for (int a = 0; a < 7; a++) wr(a, 8'(8'hC0 + a));
    wr(7, 8'h03);
    cyc(3);
    chk_act("R4 frozen");
    chk_read("R8 shadow visible before transfer");

    // R5: rising edge does nothing, falling edge loads after 3 edges
    vsync = 0; cyc(6); vsync = 1; cyc(6);
    load_model(); chk_act("R5 field load");
    wr(2, 8'h11); wr(6, 8'h22);
    vsync = 0; cyc(1); vsync = 1; cyc(6);      // one-cycle low still falls
    load_model(); chk_act("R5 short pulse load");
    wr(2, 8'h33);
    vsync = 0; cyc(2);
    check("R5 not before third edge", bright, 8'h11);
    cyc(1);
    check("R5 load on third edge", bright, 8'h33);
    cyc(3); wr(3, 8'h44); vsync = 1; cyc(6);   // rising edge
    check("R5 rise ignored", uscale, ac[3]);
    load_model(); ac[3] = 8'h80;
    for (int i = 0; i < 8; i++) ac[i] = act_port(i);
    field(); chk_act("R5 next field");

    // R6: write in the transfer clock
    wr(5, 8'h5A); old5 = 8'h5A;
    vsync = 0; cyc(2);
    wr_en = 1; wr_addr = 3'd5; wr_data = 8'hE7;
    @(negedge clk); wr_en = 0;
    check("R6 collision keeps pre-write value", contrast, old5);
    sh[5] = 8'hE7; ac[5] = old5;
    cyc(2); vsync = 1; cyc(4);
    check("R6 collision still old", contrast, old5);
    rd_addr = 3'd5; cyc(1);
    check("R6 shadow holds new", rd_data, 8'hE7);
    field(); check("R6 applied next field", contrast, 8'hE7);

    // R7: disabling buffering flushes pending values
    wr(0, 8'h9A); wr(4, 8'h6B); wr(6, 8'h7C);
    chk_act("R4 pending");
    wr(7, 8'h01);
    check("R9 dbuf cleared", {7'd0, dbuf_on}, 8'h00);
    cyc(1);
    load_model(); chk_act("R7 flush");
    field(); chk_act("R3 no field load when immediate");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule